// File: doc/BRIEF.md
# Condition Code and Interrupt Mask Unit

This unit holds the flag byte of a small 8-bit accumulator processor and decides when a hardware interrupt may enter. On each cycle it receives the ALU operation in progress along with its two operands (accumulator and memory) and a carry-in. From these it recomputes the half-carry, negative, zero and carry flags exactly as that operation requires. Single-cycle strobes from the instruction decoder set or clear the interrupt mask: clear-mask, set-mask, stop, wait and software interrupt entry. A return-from-interrupt strobe reloads the whole byte from a value pulled off the stack.

Interrupt request lines are captured into one pending latch per source. Each request is held there for as long as the mask is set. Once the mask reads 0 and any latch is set, the unit raises a take-interrupt output and reports which source won. The lowest-numbered source has the highest priority. This output tells the sequencer to stack the registers. In the same edge the unit sets the mask and clears the winning latch. On the next cycle it pulses a vector-fetch request.

Top module: `ccr_unit`

## Requirements
- R1: `ccr_o[7:5]` always reads 3'b111. Loading a stacked byte whose top three bits are 0 does not change them.
- R2: Bits 4 down to 0 of `ccr_o` are half-carry, interrupt mask, negative, zero and carry. The flags update on the clock edge that samples the operation.
- R3: For `alu_op_i` = 1 (add), the unit forms sum = acc + mem. For `alu_op_i` = 2 (add with carry), it forms sum = acc + mem + carry_i. In both cases, half-carry becomes the carry out of bit 3 and carry becomes the carry out of bit 7. Negative becomes bit 7 of the sum, and zero is set when the 8-bit sum is 0.
- R4: For `alu_op_i` = 3 (subtract), carry becomes the borrow (acc < mem), negative and zero follow acc − mem, and half-carry is unchanged. For 4 (AND) and 5 (load mem), negative and zero follow the result and half-carry and carry are unchanged. For 0, 6 and 7, no flag changes.
- R5: Reset sets the mask to 1. It leaves half-carry, negative, zero and carry unchanged. The pending latches and vector-fetch are cleared.
- R6: Set-mask and software-entry strobes set the mask on the next edge. Only the clear-mask, stop and wait strobes, or a reload from the stack, can clear it.
- R7: A request that arrives while the mask is 1 is held. Take-interrupt stays low until the mask reads 0. If a clear-mask strobe and a request arrive in the same cycle, take-interrupt rises in the following cycle.
- R8: On the edge that ends a take-interrupt cycle, the mask becomes 1 and the winning latch clears. Vector-fetch is then high for exactly one cycle. A request that arrives during the take cycle stays pending for a later entry.
- R9: A return strobe loads bits 4:0 from `stack_byte_i`, taking priority over a same-cycle ALU operation and mask strobes.
- R10: When several sources are pending, `irq_src_o` names the lowest-numbered one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_op_i | input | 3 | ALU operation code (see R3, R4) |
| acc_i | input | 8 | Accumulator operand |
| mem_i | input | 8 | Memory operand |
| carry_i | input | 1 | Carry-in for add with carry |
| cli_i | input | 1 | Clear-mask strobe |
| sei_i | input | 1 | Set-mask strobe |
| stop_i | input | 1 | Stop instruction strobe (clears mask) |
| wait_i | input | 1 | Wait instruction strobe (clears mask) |
| swi_i | input | 1 | Software interrupt entry strobe (sets mask) |
| rti_i | input | 1 | Return strobe: reload from stack byte |
| stack_byte_i | input | 8 | Byte pulled from the stack |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| ccr_o | output | 8 | Condition code byte |
| take_irq_o | output | 1 | Interrupt taken: stack registers this cycle |
| irq_src_o | output | SRC_W | Index of the source being taken |
| vec_fetch_o | output | 1 | Vector fetch request, one cycle after a take |

## Verification
The bench builds the unit with three request sources. This is enough to show the priority ordering, a request held through the take cycle and a request queued behind another. It sweeps every accumulator value against a stepped set of memory operands, with both carry-in values, for add, add with carry and subtract. Every load value is also swept. Expected flags come from arithmetic in the bench and are compared with the byte after each edge. Directed sequences cover reset with flags set, stack reloads, every mask strobe and the timing of the interrupt hand-off.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int CCR_W = 8;
    localparam int H_BIT = 4;
    localparam int I_BIT = 3;
    localparam int N_BIT = 2;
    localparam int Z_BIT = 1;
    localparam int C_BIT = 0;

    localparam logic [2:0] ALU_NOP  = 3'd0;
    localparam logic [2:0] ALU_ADD  = 3'd1;
    localparam logic [2:0] ALU_ADC  = 3'd2;
    localparam logic [2:0] ALU_SUB  = 3'd3;
    localparam logic [2:0] ALU_AND  = 3'd4;
    localparam logic [2:0] ALU_LOAD = 3'd5;

    // flag values proposed by the operation, with per-group update enables
    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic c;
        logic upd_h;
        logic upd_nz;
        logic upd_c;
    } flag_res_t;

    typedef struct packed {
        logic h;
        logic i;
        logic n;
        logic z;
        logic c;
        logic vec;
    } ccr_state_t;

endpackage

// File: rtl/ccr_flag_calc.sv
module ccr_flag_calc
    import ccr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] m_i,
    input  logic              cin_i,
    output flag_res_t         res_o
);
    localparam int HALF = DATA_W / 2;
    localparam int SW   = DATA_W + 1;
    localparam int HW   = HALF + 1;

    logic [SW-1:0]     sum_w;
    logic [HW-1:0]     half_w;
    logic [SW-1:0]     diff_w;
    logic [DATA_W-1:0] result;
    logic              add_cin;

    always_comb begin
        add_cin = (op_i == ALU_ADC) ? cin_i : 1'b0;
        sum_w   = SW'(a_i) + SW'(m_i) + SW'(add_cin);
        half_w  = HW'(a_i[HALF-1:0]) + HW'(m_i[HALF-1:0]) + HW'(add_cin);
        diff_w  = SW'(a_i) - SW'(m_i);
        res_o   = '0;
        result  = '0;
        case (op_i)
            ALU_ADD, ALU_ADC: begin
                result       = sum_w[DATA_W-1:0];
                res_o.h      = half_w[HALF];
                res_o.c      = sum_w[DATA_W];
                res_o.upd_h  = 1'b1;
                res_o.upd_c  = 1'b1;
                res_o.upd_nz = 1'b1;
            end
            ALU_SUB: begin
                result       = diff_w[DATA_W-1:0];
                res_o.c      = diff_w[DATA_W];
                res_o.upd_c  = 1'b1;
                res_o.upd_nz = 1'b1;
            end
            ALU_AND: begin
                result       = a_i & m_i;
                res_o.upd_nz = 1'b1;
            end
            ALU_LOAD: begin
                result       = m_i;
                res_o.upd_nz = 1'b1;
            end
            default: begin
                result = '0;
            end
        endcase
        res_o.n = result[DATA_W-1];
        res_o.z = (result == '0);
    end

endmodule

// File: rtl/ccr_irq_gate.sv
module ccr_irq_gate #(
    parameter int NUM_IRQ = 3,
    parameter int SRC_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               mask_i,
    output logic               take_o,
    output logic [SRC_W-1:0]   src_o
);
    logic [NUM_IRQ-1:0] pend_d;
    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] win;

    // lowest index wins
    always_comb begin
        src_o = '0;
        win   = '0;
        for (int k = NUM_IRQ - 1; k >= 0; k--) begin
            if (pend_q[k]) begin
                src_o = SRC_W'(k);
                win   = '0;
                win[k] = 1'b1;
            end
        end
        take_o = (|pend_q) && !mask_i;
    end

    generate
        for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
            always_comb begin
                pend_d[g] = (pend_q[g] && !(take_o && win[g])) || irq_i[g];
            end

            AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                pend_q[g] && !(take_o && win[g]) |=> pend_q[g]) // R7
                else $error("pending latch lost a request");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    AST_TAKE_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> $past(!mask_i && (|pend_q))) // R7
        else $error("take raised without an unmasked pending request");

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int NUM_IRQ = 3,
    parameter int DATA_W  = 8,
    parameter int SRC_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         alu_op_i,
    input  logic [DATA_W-1:0]  acc_i,
    input  logic [DATA_W-1:0]  mem_i,
    input  logic               carry_i,
    input  logic               cli_i,
    input  logic               sei_i,
    input  logic               stop_i,
    input  logic               wait_i,
    input  logic               swi_i,
    input  logic               rti_i,
    input  logic [CCR_W-1:0]   stack_byte_i,
    input  logic [NUM_IRQ-1:0] irq_i,
    output logic [CCR_W-1:0]   ccr_o,
    output logic               take_irq_o,
    output logic [SRC_W-1:0]   irq_src_o,
    output logic               vec_fetch_o
);
    flag_res_t  res;
    ccr_state_t state_d;
    ccr_state_t state_q = '0;
    logic       take;

    ccr_flag_calc #(.DATA_W(DATA_W)) u_calc (
        .op_i  (alu_op_i),
        .a_i   (acc_i),
        .m_i   (mem_i),
        .cin_i (carry_i),
        .res_o (res)
    );

    ccr_irq_gate #(.NUM_IRQ(NUM_IRQ), .SRC_W(SRC_W)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_i),
        .mask_i (state_q.i),
        .take_o (take),
        .src_o  (irq_src_o)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vec = take;
        if (rti_i) begin
            state_d.h = stack_byte_i[H_BIT];
            state_d.n = stack_byte_i[N_BIT];
            state_d.z = stack_byte_i[Z_BIT];
            state_d.c = stack_byte_i[C_BIT];
        end else begin
            if (res.upd_h)  state_d.h = res.h;
            if (res.upd_nz) begin
                state_d.n = res.n;
                state_d.z = res.z;
            end
            if (res.upd_c)  state_d.c = res.c;
        end
        if (take)                         state_d.i = 1'b1;
        else if (rti_i)                   state_d.i = stack_byte_i[I_BIT];
        else if (sei_i || swi_i)          state_d.i = 1'b1;
        else if (cli_i || stop_i || wait_i) state_d.i = 1'b0;
    end

    // only the mask and the entry pulse are reset; arithmetic flags keep their value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.i   <= 1'b1;
            state_q.vec <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ccr_o        = '1;
        ccr_o[H_BIT] = state_q.h;
        ccr_o[I_BIT] = state_q.i;
        ccr_o[N_BIT] = state_q.n;
        ccr_o[Z_BIT] = state_q.z;
        ccr_o[C_BIT] = state_q.c;
        take_irq_o   = take;
        vec_fetch_o  = state_q.vec;
    end

    AST_RESET_SETS_MASK: assert property (@(posedge clk)
        !rst_n |=> ccr_o[I_BIT]) // R5
        else $error("mask not set by reset");

    AST_MASK_CLEAR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ccr_o[I_BIT]) |-> $past(cli_i || stop_i || wait_i || rti_i)) // R6
        else $error("mask cleared without a permitted strobe");

    AST_TAKE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq_o |=> vec_fetch_o && ccr_o[I_BIT]) // R8
        else $error("entry did not mask and fetch vector");

    AST_VEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch_o |=> !vec_fetch_o) // R8
        else $error("vector fetch longer than one cycle");

    AST_H_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        !(alu_op_i == ALU_ADD || alu_op_i == ALU_ADC) && !rti_i |=> $stable(ccr_o[H_BIT])) // R4
        else $error("half-carry changed outside add");

endmodule

// File: tb/ccr_unit_tb.sv
module ccr_unit_tb;
    localparam int NI = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] alu_op = '0;
    logic [7:0] acc = '0;
    logic [7:0] mem = '0;
    logic       cin = 1'b0;
    logic       cli = 1'b0, sei = 1'b0, stp = 1'b0, wai = 1'b0, swi = 1'b0, rti = 1'b0;
    logic [7:0] sbyte = '0;
    logic [NI-1:0] irq = '0;
    logic [7:0] ccr;
    logic       take;
    logic [1:0] src;
    logic       vec;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_ccr;

    always #2 clk = ~clk;

    ccr_unit #(.NUM_IRQ(NI)) u_dut (
        .clk(clk), .rst_n(rst_n), .alu_op_i(alu_op), .acc_i(acc), .mem_i(mem),
        .carry_i(cin), .cli_i(cli), .sei_i(sei), .stop_i(stp), .wait_i(wai),
        .swi_i(swi), .rti_i(rti), .stack_byte_i(sbyte), .irq_i(irq),
        .ccr_o(ccr), .take_irq_o(take), .irq_src_o(src), .vec_fetch_o(vec)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        alu_op = '0; cli = 0; sei = 0; stp = 0; wai = 0; swi = 0; rti = 0; irq = '0;
    endtask

    // apply one ALU operation and compare the byte after the edge
    task automatic alu(input logic [2:0] op, input logic [7:0] a, input logic [7:0] m,
                       input logic ci, input string req);
        logic [8:0] s;
        logic [4:0] hs;
        logic [7:0] r;
        alu_op = op; acc = a; mem = m; cin = ci;
        step();
        alu_op = '0;
        r = exp_ccr;
        case (op)
            3'd1, 3'd2: begin
                s  = 9'(a) + 9'(m) + ((op == 3'd2) ? 9'(ci) : 9'd0);
                hs = 5'(a[3:0]) + 5'(m[3:0]) + ((op == 3'd2) ? 5'(ci) : 5'd0);
                exp_ccr[4] = hs[4];
                exp_ccr[0] = s[8];
                r = s[7:0];
            end
            3'd3: begin
                exp_ccr[0] = (a < m);
                r = a - m;
            end
            3'd4: r = a & m;
            3'd5: r = m;
            default: r = '0;
        endcase
        if (op inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}) begin
            exp_ccr[2] = r[7];
            exp_ccr[1] = (r == 8'd0);
        end
        check(req, ccr, exp_ccr);
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1;
        step(); step();
        exp_ccr = 8'hE8;
        check("R5 reset byte", ccr, exp_ccr);
        check("R5 take after reset", {7'd0, take}, 8'd0);
        check("R5 vec after reset", {7'd0, vec}, 8'd0);
        rst_n = 1;
        step();

        // R3 add sweep
        for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m += 3)
                alu(3'd1, 8'(a), 8'(m), 1'b1, "R3 add");
        // R3 add with carry sweep
        for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m += 5)
                for (int c = 0; c < 2; c++)
                    alu(3'd2, 8'(a), 8'(m), 1'(c), "R3 adc");
        // R2 layout: 0x88+0x88 -> H and C only
        alu(3'd1, 8'h88, 8'h88, 1'b0, "R2 H/C position");
        check("R2 exact layout", ccr, 8'hF9);
        // R4 subtract sweep (H must hold at 1)
        for (int a = 0; a < 256; a++)
            for (int m = 0; m < 256; m += 7)
                alu(3'd3, 8'(a), 8'(m), 1'b0, "R4 sub");
        alu(3'd1, 8'h88, 8'h88, 1'b0, "R3 set H C");
        for (int m = 0; m < 256; m++)
            alu(3'd5, 8'h00, 8'(m), 1'b0, "R4 load");
        for (int m = 0; m < 256; m += 3)
            alu(3'd4, 8'hA5, 8'(m), 1'b0, "R4 and");
        alu(3'd0, 8'hFF, 8'hFF, 1'b1, "R4 nop");
        alu(3'd6, 8'hFF, 8'h01, 1'b1, "R4 op6");
        alu(3'd7, 8'h00, 8'h00, 1'b0, "R4 op7");

        // R5 reset keeps H N Z C
        alu(3'd1, 8'h88, 8'h88, 1'b0, "R5 prep");
        rst_n = 0; step(); step(); rst_n = 1;
        check("R5 reset keeps flags", ccr, 8'hF9);
        step();

        // R9 / R1 reloads
        rti = 1; sbyte = 8'h00; step(); clear_in();
        check("R1 R9 reload zero", ccr, 8'hE0);
        rti = 1; sbyte = 8'h1F; step(); clear_in();
        check("R9 reload all", ccr, 8'hFF);
        rti = 1; sbyte = 8'h15; alu_op = 3'd1; acc = 8'hFF; mem = 8'h01; sei = 1;
        step(); clear_in();
        check("R9 reload wins", ccr, 8'hF5);

        // R6 mask strobes (I currently 0)
        sei = 1; step(); clear_in();
        check("R6 sei", {7'd0, ccr[3]}, 8'd1);
        alu(3'd1, 8'h01, 8'h01, 1'b0, "R6 prep");
        check("R6 alu keeps mask", {7'd0, ccr[3]}, 8'd1);
        step(); step();
        check("R6 mask held idle", {7'd0, ccr[3]}, 8'd1);
        cli = 1; step(); clear_in();
        check("R6 cli", {7'd0, ccr[3]}, 8'd0);
        swi = 1; step(); clear_in();
        check("R6 swi", {7'd0, ccr[3]}, 8'd1);
        stp = 1; step(); clear_in();
        check("R6 stop", {7'd0, ccr[3]}, 8'd0);
        sei = 1; step(); clear_in();
        wai = 1; step(); clear_in();
        check("R6 wait", {7'd0, ccr[3]}, 8'd0);
        sei = 1; step(); clear_in();

        // R7 masked request held
        irq = 3'b010; step(); clear_in();
        check("R7 masked no take", {7'd0, take}, 8'd0);
        step(); step();
        check("R7 still held", {7'd0, take}, 8'd0);
        cli = 1; step(); clear_in();
        check("R7 take after cli", {7'd0, take}, 8'd1);
        check("R10 src one", {6'd0, src}, 8'd1);
        irq = 3'b100; step(); clear_in();
        check("R8 mask set", {7'd0, ccr[3]}, 8'd1);
        check("R8 vec pulse", {7'd0, vec}, 8'd1);
        check("R8 take cleared", {7'd0, take}, 8'd0);
        step();
        check("R8 vec one cycle", {7'd0, vec}, 8'd0);
        cli = 1; step(); clear_in();
        check("R8 held request taken", {7'd0, take}, 8'd1);
        check("R8 held src", {6'd0, src}, 8'd2);
        step(); step();
        check("R8 latch cleared", {7'd0, take}, 8'd0);
        irq = 3'b101; step(); clear_in();
        cli = 1; step(); clear_in();
        check("R10 lowest first", {6'd0, src}, 8'd0);
        step();
        cli = 1; step(); clear_in();
        check("R10 next source", {6'd0, src}, 8'd2);
        check("R10 take second", {7'd0, take}, 8'd1);
        step();
        // R7 CLI and request together
        cli = 1; irq = 3'b001; step(); clear_in();
        check("R7 coincide take", {7'd0, take}, 8'd1);
        step();
        check("R8 no spurious take", {7'd0, take}, 8'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule